// File: doc/BRIEF.md
# Line-Side Control Register with Remote Loopback

This block holds one 8-bit control register that a host writes and reads over a simple address/data port. It drives the digital line-side path of a T1 transceiver. Three of its bits are reset requests. Each one produces a single-cycle reset pulse only when the host changes that bit from 0 to 1. Two further bits, the sync-input select and the open-drain option, are exported as static levels for the analog side.

On the transmit side the block chooses one of three sources for the positive/negative rail outputs. The normal source is the transmit formatter. In remote loopback, the receive rails are sent back out. When the disconnect pattern is enabled, the block sends an unframed alternating mark/space pattern as AMI marks that take turns on the two rails. The receive rails always reach the receive framer outputs unchanged, whatever transmit source is selected.

The pattern comes from a small state machine with five states:
- `PAT_IDLE`: both rails low.
- `PAT_MARK_P`: positive rail high.
- `PAT_SPACE_A`: both rails low.
- `PAT_MARK_N`: negative rail high.
- `PAT_SPACE_B`: both rails low.

Its transitions are:
- IDLE→MARK_P when the pattern is enabled.
- MARK_P→SPACE_A, SPACE_A→MARK_N, MARK_N→SPACE_B and SPACE_B→MARK_P, each taken on every clock while the pattern is enabled.
- From any state back to IDLE when the pattern is disabled.

Top module: `line_ctrl_top`

## Requirements
- R1: A write with `wr_en` high and `addr` = 0x0A stores `wr_data` on the clock edge. `rd_data` returns the stored byte with bit 3 forced to 0. Writes to any other address change nothing, and reads there return 0.
- R2: Register bit 7 (line-interface reset) drives `liu_rst_pulse` high for exactly one cycle, starting in the cycle after a write takes the bit from 0 to 1. Rewriting 1 over 1 produces no pulse.
- R3: Register bit 5 (receive elastic-store reset, minimum delay) drives `rx_es_rst_pulse` under the same 0-to-1 rule as R2.
- R4: Register bit 4 (transmit elastic-store reset, maximum delay, transmit data discarded) drives `tx_es_rst_pulse` under the same 0-to-1 rule as R2.
- R5: While bit 6 (remote loopback) is 1, `tx_pos`/`tx_neg` equal `rx_pos`/`rx_neg` in the same cycle, and `fmt_pos`/`fmt_neg` have no effect on them.
- R6: `rxf_pos`/`rxf_neg` always equal `rx_pos`/`rx_neg`, in every mode.
- R7: While bit 1 (disconnect pattern) is 1 and bit 6 is 0, the transmit rails follow the pattern states. The first cycle after enabling is (0,0), then (1,0), (0,0), (0,1), (0,0), and the sequence repeats with period 4.
- R8: Remote loopback has priority over the disconnect pattern.
- R9: `sync_sel` equals bit 2 and `open_drain` equals bit 0. Neither bit changes the transmit rails.
- R10: After reset the register is 0, no reset pulse is asserted, and the transmit rails carry `fmt_pos`/`fmt_neg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| rx_pos | input | 1 | Receive positive rail |
| rx_neg | input | 1 | Receive negative rail |
| fmt_pos | input | 1 | Transmit formatter positive rail |
| fmt_neg | input | 1 | Transmit formatter negative rail |
| tx_pos | output | 1 | Transmit positive rail |
| tx_neg | output | 1 | Transmit negative rail |
| rxf_pos | output | 1 | Receive framer positive rail |
| rxf_neg | output | 1 | Receive framer negative rail |
| liu_rst_pulse | output | 1 | Line-interface reset pulse |
| rx_es_rst_pulse | output | 1 | Receive elastic-store reset pulse |
| tx_es_rst_pulse | output | 1 | Transmit elastic-store reset pulse |
| sync_sel | output | 1 | Sync-input select level |
| open_drain | output | 1 | Open-drain option level |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is asserted before the first clock edge.
- The host changes `wr_en`, `addr` and `wr_data` only away from the rising edge.

The bench meets both by driving every input at the falling edge, and it releases reset only after several cycles. The pulse and pattern properties are stated relative to register state, so they hold for any write sequence. The bench covers this space in three ways:
- It sweeps every register value.
- It sweeps every old/new pair of the three reset bits.
- It sweeps every combination of loopback, pattern enable and rail inputs.

// File: rtl/line_ctrl_pkg.sv
package line_ctrl_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_RST   = 3;
    localparam int BIT_LIURST = 7;
    localparam int BIT_LOOP   = 6;
    localparam int BIT_RXES   = 5;
    localparam int BIT_TXES   = 4;
    localparam int BIT_RSVD   = 3;
    localparam int BIT_SYNC   = 2;
    localparam int BIT_CDIS   = 1;
    localparam int BIT_ODRN   = 0;

    typedef enum logic [2:0] {
        PAT_IDLE    = 3'd0,
        PAT_MARK_P  = 3'd1,
        PAT_SPACE_A = 3'd2,
        PAT_MARK_N  = 3'd3,
        PAT_SPACE_B = 3'd4
    } pat_state_t;
endpackage

// File: rtl/line_ctrl_regs.sv
module line_ctrl_regs
    import line_ctrl_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h0A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_RST-1:0]  rst_bits,
    output logic                loop_en,
    output logic                sync_en,
    output logic                cdis_en,
    output logic                odrn_en
);
    localparam logic [DATA_W-1:0] RSVD_MASK = ~(DATA_W'(1) << BIT_RSVD);

    logic [DATA_W-1:0] ctrl_q;
    logic              hit;

    assign hit = (addr == REG_ADDR[ADDR_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && hit) begin
            ctrl_q <= wr_data & RSVD_MASK;
        end
    end

    always_comb begin
        rd_data = hit ? ctrl_q : '0;
    end

    assign rst_bits = {ctrl_q[BIT_LIURST], ctrl_q[BIT_RXES], ctrl_q[BIT_TXES]};
    assign loop_en  = ctrl_q[BIT_LOOP];
    assign sync_en  = ctrl_q[BIT_SYNC];
    assign cdis_en  = ctrl_q[BIT_CDIS];
    assign odrn_en  = ctrl_q[BIT_ODRN];

    // R1: the reserved bit never reads back as 1
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_RSVD] == 1'b0);
endmodule

// File: rtl/line_ctrl_edge.sv
module line_ctrl_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] pulse
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign pulse[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/line_ctrl_altgen.sv
module line_ctrl_altgen
    import line_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic pat_pos,
    output logic pat_neg
);
    pat_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PAT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = PAT_IDLE;
        end else begin
            unique case (state_q)
                PAT_IDLE:    state_d = PAT_MARK_P;
                PAT_MARK_P:  state_d = PAT_SPACE_A;
                PAT_SPACE_A: state_d = PAT_MARK_N;
                PAT_MARK_N:  state_d = PAT_SPACE_B;
                PAT_SPACE_B: state_d = PAT_MARK_P;
                default:     state_d = PAT_IDLE;
            endcase
        end
    end

    always_comb begin
        pat_pos = 1'b0;
        pat_neg = 1'b0;
        unique case (state_q)
            PAT_MARK_P: pat_pos = 1'b1;
            PAT_MARK_N: pat_neg = 1'b1;
            default: ;
        endcase
    end

    // R7: a mark is always followed by a space
    p_mark_then_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_pos || pat_neg) |=> (!pat_pos && !pat_neg));
    // R7: a positive mark is followed two cycles later by a negative mark or idle
    p_alt_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_pos && enable) |=> ##1 (!pat_pos));
endmodule

// File: rtl/line_ctrl_top.sv
module line_ctrl_top
    import line_ctrl_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              rx_pos,
    input  logic              rx_neg,
    input  logic              fmt_pos,
    input  logic              fmt_neg,
    output logic              tx_pos,
    output logic              tx_neg,
    output logic              rxf_pos,
    output logic              rxf_neg,
    output logic              liu_rst_pulse,
    output logic              rx_es_rst_pulse,
    output logic              tx_es_rst_pulse,
    output logic              sync_sel,
    output logic              open_drain
);
    logic [NUM_RST-1:0] rst_bits;
    logic [NUM_RST-1:0] rst_pulse;
    logic loop_en, cdis_en, pat_pos, pat_neg;

    line_ctrl_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rst_bits(rst_bits),
        .loop_en(loop_en), .sync_en(sync_sel), .cdis_en(cdis_en),
        .odrn_en(open_drain)
    );

    line_ctrl_edge #(.N(NUM_RST)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(rst_bits), .pulse(rst_pulse)
    );

    line_ctrl_altgen altgen_i (
        .clk(clk), .rst_n(rst_n), .enable(cdis_en),
        .pat_pos(pat_pos), .pat_neg(pat_neg)
    );

    assign liu_rst_pulse   = rst_pulse[2];
    assign rx_es_rst_pulse = rst_pulse[1];
    assign tx_es_rst_pulse = rst_pulse[0];

    assign rxf_pos = rx_pos;
    assign rxf_neg = rx_neg;

    always_comb begin
        if (loop_en) begin
            tx_pos = rx_pos;
            tx_neg = rx_neg;
        end else if (cdis_en) begin
            tx_pos = pat_pos;
            tx_neg = pat_neg;
        end else begin
            tx_pos = fmt_pos;
            tx_neg = fmt_neg;
        end
    end

    p_liu_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        liu_rst_pulse |=> !liu_rst_pulse);
    p_liu_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        liu_rst_pulse |-> rst_bits[2]);
    p_rxes_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_es_rst_pulse |=> !rx_es_rst_pulse);
    p_txes_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_es_rst_pulse |=> !tx_es_rst_pulse);
    p_pattern_no_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cdis_en && !loop_en) |-> !(tx_pos && tx_neg));
endmodule

// File: tb/line_ctrl_top_tb_top.sv
module line_ctrl_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] addr = 8'h0A;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic rx_pos = 1'b0, rx_neg = 1'b0, fmt_pos = 1'b0, fmt_neg = 1'b0;
    logic tx_pos, tx_neg, rxf_pos, rxf_neg;
    logic liu_p, rxes_p, txes_p, sync_sel, open_drain;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    line_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .fmt_pos(fmt_pos), .fmt_neg(fmt_neg),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .rxf_pos(rxf_pos), .rxf_neg(rxf_neg),
        .liu_rst_pulse(liu_p), .rx_es_rst_pulse(rxes_p),
        .tx_es_rst_pulse(txes_p), .sync_sel(sync_sel), .open_drain(open_drain)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h0A;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reg", rd_data, 8'h00);
        chk("R10 pulses", {5'b0, liu_p, rxes_p, txes_p}, 8'h00);
        fmt_pos = 1'b1; fmt_neg = 1'b0; #1;
        chk("R10 tx", {6'b0, tx_pos, tx_neg}, 8'h02);

        // R1 and R9: every register value
        for (int v = 0; v < 256; v++) begin
            wr(8'h0A, 8'(v));
            chk("R1 readback", rd_data, 8'(v) & 8'hF7);
            chk("R9 levels", {6'b0, sync_sel, open_drain}, {6'b0, v[2], v[0]});
        end
        wr(8'h0A, 8'h00);
        // R1: write to another address is ignored and reads 0
        wr(8'h0B, 8'hFF);
        chk("R1 other addr read", rd_data, 8'h00);
        addr = 8'h0B; #1;
        chk("R1 other addr zero", rd_data, 8'h00);
        addr = 8'h0A; #1;

        // R2 R3 R4: all old/new pairs of the reset bits
        for (int p = 0; p < 8; p++) begin
            for (int n = 0; n < 8; n++) begin
                logic [7:0] pv, nv, expp;
                pv = {p[2], 1'b0, p[1], p[0], 4'b0};
                nv = {n[2], 1'b0, n[1], n[0], 4'b0};
                wr(8'h0A, pv);
                @(negedge clk);
                wr(8'h0A, nv);
                expp = {5'b0, 3'(n & ~p)};
                chk("R2 R3 R4 pulse", {5'b0, liu_p, rxes_p, txes_p}, expp);
                @(negedge clk);
                chk("R2 R3 R4 width", {5'b0, liu_p, rxes_p, txes_p}, 8'h00);
            end
        end
        // R2: rewriting 1 over 1 does not refire
        wr(8'h0A, 8'h80);
        @(negedge clk);
        wr(8'h0A, 8'h80);
        chk("R2 no refire", {7'b0, liu_p}, 8'h00);

        // R5 R6 R8 R9: mode x rail sweep
        for (int m = 0; m < 16; m++) begin
            wr(8'h0A, {1'b0, m[0], 3'b0, m[2], m[1], m[3]});
            for (int r = 0; r < 16; r++) begin
                logic [1:0] ex;
                {rx_pos, rx_neg, fmt_pos, fmt_neg} = 4'(r);
                #1;
                chk("R6 rx to framer", {6'b0, rxf_pos, rxf_neg}, {6'b0, 2'(r >> 2)});
                if (m[0]) begin
                    ex = 2'(r >> 2);
                    chk("R5 R8 loopback", {6'b0, tx_pos, tx_neg}, {6'b0, ex});
                end else if (!m[1]) begin
                    ex = 2'(r);
                    chk("R9 normal path", {6'b0, tx_pos, tx_neg}, {6'b0, ex});
                end
            end
        end

        // R7: pattern sequence
        wr(8'h0A, 8'h00);
        fmt_pos = 1'b1; fmt_neg = 1'b1;
        wr(8'h0A, 8'h02);
        chk("R7 first space", {6'b0, tx_pos, tx_neg}, 8'h00);
        for (int k = 0; k < 12; k++) begin
            logic [1:0] ex;
            @(negedge clk);
            case (k % 4)
                0: ex = 2'b10;
                2: ex = 2'b01;
                default: ex = 2'b00;
            endcase
            chk("R7 pattern", {6'b0, tx_pos, tx_neg}, {6'b0, ex});
        end
        wr(8'h0A, 8'h00);
        chk("R7 disable returns fmt", {6'b0, tx_pos, tx_neg}, 8'h03);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule